// File: doc/BRIEF.md
# Masked Coincidence Trigger with Comma-Led Crossing Frame

Once per bunch crossing this block takes one byte from each of twelve sources and forms eight independent coincidence decisions. Each decision has its own 96-bit mask, one bit per source bit, where a set bit removes that input bit. After masking, the block counts the sources whose byte is still non-zero, giving a count of 0 to 12. It then compares that count with a 4-bit threshold for that decision. The eight decision bits make up one byte.

The block builds a four-byte frame for each crossing and sends it one byte per clock, starting on the cycle after the crossing strobe. The frame holds a comma control character, a header byte with the first-crossing flag, a version number and the top bits of the crossing number, then the low crossing-number byte, and last the decision byte. A later line encoder and serializer take this byte stream. A single write port updates the mask and threshold of one decision at a time, and this can happen at any moment. Every frame is evaluated with one consistent set of settings.

Top module: `coinc_trigger_top`

## Requirements
- R1: After reset, out_valid, out_is_k and out_byte are all zero. Before any write, every mask is all zeros and every threshold is 15, so every decision bit is 0.
- R2: Mask bit s*8+b applies to bit b of source s, where source s is src_bytes[s*8+7:s*8]. A mask bit of 1 means that input bit cannot make its source count as non-zero.
- R3: Decision t is 1 when the number of sources with a non-zero masked byte is at least its threshold. A threshold of 0 always fires.
- R4: A threshold of 13, 14 or 15 never fires, even when all twelve sources are active.
- R5: On the cycle after the clock edge that samples xing_strobe high, out_byte is 0xBC, out_is_k is 1 and out_valid is 1. out_is_k is never 1 with any other byte.
- R6: The second frame byte comes on the next cycle. It carries first_xing in bit 7, the value 1 in bits 6:4, and xing_num[11:8] in bits 3:0.
- R7: On the two cycles after that come xing_num[7:0], then the decision byte with decision t in bit t. out_is_k is 0 for both. On the cycle after the decision byte, out_valid is 0.
- R8: A configuration write (cfg_we with cfg_sel, cfg_mask, cfg_thresh) is used by every crossing whose strobe is sampled after the write edge. A write sampled on the same edge as a strobe does not affect that crossing's frame; it applies from the next crossing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_bytes | input | 96 | Twelve source bytes; source s in bits s*8+7:s*8 |
| xing_strobe | input | 1 | One-cycle pulse marking a crossing, at least 5 cycles apart |
| xing_num | input | 12 | Crossing number for this crossing |
| first_xing | input | 1 | Marks the first crossing of an orbit |
| cfg_we | input | 1 | Write enable for one decision's settings |
| cfg_sel | input | 3 | Index of the decision being written |
| cfg_mask | input | 96 | New mask; 1 disables an input bit |
| cfg_thresh | input | 4 | New threshold; values 13 to 15 never fire |
| out_byte | output | 8 | Frame byte |
| out_is_k | output | 1 | Marks out_byte as a control character |
| out_valid | output | 1 | A frame byte is present |

## Verification
The case that needs care is a settings write arriving in the same cycle as a crossing strobe. The new mask or threshold must not leak into the frame that this strobe starts, but it must apply to the following crossing. The bench drives cfg_we and xing_strobe on the same edge, with a threshold change that flips the decision. It expects the old result in the first frame's last byte and the new result in the next frame's last byte. Random source bytes with roughly half of them zero, together with random masks and thresholds, cover counts around every threshold value.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  localparam int NUM_SRC  = 12;
  localparam int BYTE_W   = 8;
  localparam int NUM_TRIG = 8;
  localparam int XING_W   = 12;
  localparam int TH_W     = 4;
  localparam int CNT_W    = $clog2(NUM_SRC + 1);
  localparam int MASK_W   = NUM_SRC * BYTE_W;
  localparam int SEL_W    = $clog2(NUM_TRIG);
  localparam logic [2:0]        FRAME_VER = 3'd1;
  localparam logic [BYTE_W-1:0] COMMA_K   = 8'hBC;

  // number of sources whose byte survives the mask as non-zero
  function automatic logic [CNT_W-1:0] masked_count(
    input logic [MASK_W-1:0] data,
    input logic [MASK_W-1:0] mask
  );
    logic [CNT_W-1:0] n;
    n = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if ((data[s*BYTE_W +: BYTE_W] & ~mask[s*BYTE_W +: BYTE_W]) != '0)
        n = n + 1'b1;
    end
    return n;
  endfunction

  // threshold compare; thresholds beyond the source count are inert
  function automatic logic thresh_hit(
    input logic [CNT_W-1:0] cnt,
    input logic [TH_W-1:0]  th
  );
    return (32'(th) <= NUM_SRC) && (32'(cnt) >= 32'(th));
  endfunction
endpackage

// File: rtl/coinc_cfg_bank.sv
module coinc_cfg_bank
  import coinc_pkg::*;
#(
  parameter int NT = NUM_TRIG,
  parameter int MW = MASK_W,
  parameter int TW = TH_W,
  localparam int SW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [SW-1:0]   sel,
  input  logic [MW-1:0]   wmask,
  input  logic [TW-1:0]   wth,
  output logic [NT*MW-1:0] mask_flat,
  output logic [NT*TW-1:0] th_flat
);
  genvar t;
  generate
    for (t = 0; t < NT; t++) begin : g_slot
      logic [MW-1:0] mask_q;
      logic [TW-1:0] th_q;
      wire           hit_sel = we && (32'(sel) == t);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mask_q <= '0;
          th_q   <= '1;
        end else if (hit_sel) begin
          mask_q <= wmask;
          th_q   <= wth;
        end
      end
      assign mask_flat[t*MW +: MW] = mask_q;
      assign th_flat[t*TW +: TW]   = th_q;
    end
  endgenerate

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(mask_flat) && $stable(th_flat))); // R8
endmodule

// File: rtl/coinc_eval.sv
module coinc_eval
  import coinc_pkg::*;
#(
  parameter int NT = NUM_TRIG,
  parameter int MW = MASK_W,
  parameter int TW = TH_W,
  parameter int CW = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MW-1:0]    data,
  input  logic [NT*MW-1:0] mask_flat,
  input  logic [NT*TW-1:0] th_flat,
  output logic [NT-1:0]    hits
);
  genvar t;
  generate
    for (t = 0; t < NT; t++) begin : g_trig
      wire [TW-1:0] th_w    = th_flat[t*TW +: TW];
      wire [CW-1:0] count_w = masked_count(data, mask_flat[t*MW +: MW]);
      wire          hit_w   = thresh_hit(count_w, th_w);
      assign hits[t] = hit_w;

      AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count_w) <= NUM_SRC); // R2
      AST_ZERO_TH_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (th_w == '0) |-> hit_w); // R3
      AST_HIGH_TH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(th_w) > NUM_SRC) |-> !hit_w); // R4
    end
  endgenerate
endmodule

// File: rtl/coinc_framer.sv
module coinc_framer
  import coinc_pkg::*;
#(
  parameter int NT = NUM_TRIG,
  parameter int XW = XING_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          first,
  input  logic [XW-1:0] xnum,
  input  logic [NT-1:0] trig,
  output logic [BW-1:0] out_byte,
  output logic          out_k,
  output logic          out_valid,
  output logic [1:0]    frame_pos
);
  logic [BW-1:0] hdr_q, xlo_q, trg_q;
  logic [BW-1:0] byte_q;
  logic          k_q, v_q;
  logic [1:0]    pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_q  <= '0;
      xlo_q  <= '0;
      trg_q  <= '0;
      byte_q <= '0;
      k_q    <= 1'b0;
      v_q    <= 1'b0;
      pos_q  <= '0;
    end else if (strobe) begin
      hdr_q  <= {first, FRAME_VER, xnum[XW-1 -: 4]};
      xlo_q  <= xnum[7:0];
      trg_q  <= BW'(trig);
      byte_q <= COMMA_K;
      k_q    <= 1'b1;
      v_q    <= 1'b1;
      pos_q  <= 2'd0;
    end else if (v_q) begin
      k_q <= 1'b0;
      if (pos_q == 2'd3) begin
        v_q    <= 1'b0;
        byte_q <= '0;
        pos_q  <= 2'd0;
      end else begin
        pos_q <= pos_q + 2'd1;
        unique case (pos_q)
          2'd0:    byte_q <= hdr_q;
          2'd1:    byte_q <= xlo_q;
          default: byte_q <= trg_q;
        endcase
      end
    end
  end

  assign out_byte  = byte_q;
  assign out_k     = k_q;
  assign out_valid = v_q;
  assign frame_pos = pos_q;

  AST_COMMA_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (out_k && out_valid && out_byte == COMMA_K)); // R5
  AST_K_ONLY_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    out_k |-> (out_byte == COMMA_K && frame_pos == 2'd0)); // R5
  AST_VER_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && frame_pos == 2'd1) |-> (out_byte[6:4] == FRAME_VER)); // R6
  AST_BYTE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !strobe && frame_pos != 2'd3) |=> (out_valid && !out_k)); // R7
  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !strobe && frame_pos == 2'd3) |=> !out_valid); // R7
endmodule

// File: rtl/coinc_trigger_top.sv
module coinc_trigger_top
  import coinc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MASK_W-1:0]  src_bytes,
  input  logic               xing_strobe,
  input  logic [XING_W-1:0]  xing_num,
  input  logic               first_xing,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [MASK_W-1:0]  cfg_mask,
  input  logic [TH_W-1:0]    cfg_thresh,
  output logic [BYTE_W-1:0]  out_byte,
  output logic               out_is_k,
  output logic               out_valid
);
  logic [NUM_TRIG*MASK_W-1:0] mask_flat;
  logic [NUM_TRIG*TH_W-1:0]   th_flat;
  logic [NUM_TRIG-1:0]        trig_hits;
  logic [1:0]                 frame_pos;

  coinc_cfg_bank #(.NT(NUM_TRIG), .MW(MASK_W), .TW(TH_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wmask(cfg_mask), .wth(cfg_thresh),
    .mask_flat(mask_flat), .th_flat(th_flat)
  );

  coinc_eval #(.NT(NUM_TRIG), .MW(MASK_W), .TW(TH_W), .CW(CNT_W)) u_eval (
    .clk(clk), .rst_n(rst_n), .data(src_bytes),
    .mask_flat(mask_flat), .th_flat(th_flat), .hits(trig_hits)
  );

  coinc_framer #(.NT(NUM_TRIG), .XW(XING_W), .BW(BYTE_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .strobe(xing_strobe), .first(first_xing),
    .xnum(xing_num), .trig(trig_hits),
    .out_byte(out_byte), .out_k(out_is_k), .out_valid(out_valid),
    .frame_pos(frame_pos)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !out_is_k && out_byte == '0)); // R1
endmodule

// File: tb/tb_coinc_trigger_top.sv
`timescale 1ns/1ps
module tb_coinc_trigger_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] src_bytes = '0;
  logic        xing_strobe = 1'b0;
  logic [11:0] xing_num = '0;
  logic        first_xing = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [95:0] cfg_mask = '0;
  logic [3:0]  cfg_thresh = '0;
  logic [7:0]  out_byte;
  logic        out_is_k;
  logic        out_valid;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [95:0] m_mask [8];
  logic [3:0]  m_th [8];

  always #4 clk = ~clk;

  coinc_trigger_top dut (
    .clk(clk), .rst_n(rst_n), .src_bytes(src_bytes), .xing_strobe(xing_strobe),
    .xing_num(xing_num), .first_xing(first_xing), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_mask(cfg_mask), .cfg_thresh(cfg_thresh),
    .out_byte(out_byte), .out_is_k(out_is_k), .out_valid(out_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // bench model: bit-by-bit scan per source, then compare
  function automatic logic [7:0] model_trig(input logic [95:0] d);
    logic [7:0] r;
    for (int t = 0; t < 8; t++) begin
      int active = 0;
      for (int s = 0; s < 12; s++) begin
        bit any = 0;
        for (int b = 0; b < 8; b++)
          if (d[s*8+b] && !m_mask[t][s*8+b]) any = 1;
        if (any) active++;
      end
      r[t] = (m_th[t] < 4'd13) && (active >= int'(m_th[t]));
    end
    return r;
  endfunction

  task automatic cfg_write(input int t, input logic [95:0] m, input logic [3:0] th);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(t); cfg_mask = m; cfg_thresh = th;
    @(negedge clk);
    cfg_we = 1'b0;
    m_mask[t] = m; m_th[t] = th;
  endtask

  // one crossing, optionally with a config write on the strobe edge
  task automatic crossing(input logic [95:0] d, input logic [11:0] n, input bit f,
                          input bit wr, input int wt, input logic [95:0] wm,
                          input logic [3:0] wth, input string req);
    logic [7:0] exp_trig;
    @(negedge clk);
    src_bytes = d; xing_num = n; first_xing = f; xing_strobe = 1'b1;
    exp_trig = model_trig(d);
    if (wr) begin
      cfg_we = 1'b1; cfg_sel = 3'(wt); cfg_mask = wm; cfg_thresh = wth;
    end
    @(negedge clk);
    xing_strobe = 1'b0;
    if (wr) begin
      cfg_we = 1'b0; m_mask[wt] = wm; m_th[wt] = wth;
    end
    src_bytes = '0;
    check("R5 comma", {22'd0, out_valid, out_is_k, out_byte}, {22'd0, 1'b1, 1'b1, 8'hBC});
    @(negedge clk);
    check("R6 header", {22'd0, out_valid, out_is_k, out_byte},
          {22'd0, 1'b1, 1'b0, f, 3'd1, n[11:8]});
    @(negedge clk);
    check("R7 xing low", {22'd0, out_valid, out_is_k, out_byte}, {22'd0, 1'b1, 1'b0, n[7:0]});
    @(negedge clk);
    check({req, " trig byte"}, {22'd0, out_valid, out_is_k, out_byte},
          {22'd0, 1'b1, 1'b0, exp_trig});
    @(negedge clk);
    check("R7 frame end", {31'd0, out_valid}, 32'd0);
  endtask

  function automatic logic [95:0] rand_data();
    logic [95:0] d;
    for (int s = 0; s < 12; s++)
      d[s*8 +: 8] = ($urandom % 2) ? 8'($urandom) : 8'h00;
    return d;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int t = 0; t < 8; t++) begin m_mask[t] = '0; m_th[t] = 4'hF; end
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {22'd0, out_valid, out_is_k, out_byte}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {22'd0, out_valid, out_is_k, out_byte}, 32'd0);
    crossing({96{1'b1}}, 12'hA5C, 1'b1, 0, 0, '0, '0, "R1 default config");

    // R3: threshold 0 fires on silent inputs
    cfg_write(0, '0, 4'd0);
    crossing('0, 12'h001, 1'b0, 0, 0, '0, '0, "R3 zero threshold");
    // R4: thresholds above 12 silent with all sources active
    cfg_write(1, '0, 4'd13);
    cfg_write(2, '0, 4'd15);
    cfg_write(3, '0, 4'd12);
    crossing({12{8'h80}}, 12'hFFF, 1'b1, 0, 0, '0, '0, "R4 high threshold");
    // R3 boundary: 11 active sources against threshold 12
    crossing({8'h00, {11{8'h01}}}, 12'h7F0, 1'b0, 0, 0, '0, '0, "R3 count below");
    // R2: mask removes the only set bit of source 5
    cfg_write(4, 96'h1 << 40, 4'd1);
    crossing(96'h1 << 40, 12'h123, 1'b0, 0, 0, '0, '0, "R2 mask bit");
    crossing(96'h3 << 40, 12'h124, 1'b0, 0, 0, '0, '0, "R2 other bit");

    // R8: write on strobe edge lands on the next crossing
    cfg_write(5, '0, 4'd1);
    crossing({12{8'h11}}, 12'h200, 1'b0, 1, 5, '0, 4'd14, "R8 same-cycle write");
    crossing({12{8'h11}}, 12'h201, 1'b0, 0, 0, '0, '0, "R8 next crossing");

    // random mix of data, masks and thresholds
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 3 == 0) begin
        logic [95:0] m;
        m = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
        cfg_write(int'($urandom % 8), m, 4'($urandom));
      end
      if ($urandom % 5 == 0)
        crossing(rand_data(), 12'($urandom), 1'($urandom), 1, int'($urandom % 8),
                 {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom},
                 4'($urandom), "R8 random");
      else
        crossing(rand_data(), 12'($urandom), 1'($urandom), 0, 0, '0, '0, "R3 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule